// File: doc/BRIEF.md
# Partitioned Shared Fetch FIFO

This block keeps pixel data fetched from display memory until the screen-refresh and video-playback pipelines consume it. A single storage array of 32 words, each 64 bits wide, is divided into three independent circular queues. Channel 0 serves graphics screen refresh. Channels 1 and 2 serve the two video lines. Each queue occupies one contiguous region of the array, given by a start index and a length, and its read and write offsets wrap only inside that region.

Software sets each region through a configuration port. The port accepts a write only while every channel is empty, so a change of layout never strands data. The fetch side pushes into one channel per cycle and the consumer side pops from one channel per cycle. A push and a pop aimed at different channels both take effect in the same cycle. Each channel reports full, empty and a fill count. A flush input empties all three queues at once.

Top module: `shared_fetch_fifo`

## Requirements
- R1: After reset all three channels are empty with a count of 0, and the regions are channel 0 at index 0 with 16 entries, channel 1 at index 16 with 8 entries and channel 2 at index 24 with 8 entries.
- R2: A pop accepted at a clock edge drives `pop_rvalid` high and presents that channel's oldest word on `pop_data` directly after that same edge. Each channel returns words in the order they were pushed.
- R3: A channel is full when its count equals its region size. A push to a full channel is ignored.
- R4: A pop from an empty channel is ignored: `pop_rvalid` stays low and the count stays 0.
- R5: Data pushed into one channel is never returned by another channel, whatever the order in which channels are interleaved.
- R6: Write and read positions wrap at the end of their own region, so ordering holds across many more pushes than the region size and neighbouring regions are left intact.
- R7: A push to one channel and a pop from a different channel in the same cycle both take effect.
- R8: If a push and a pop name the same channel in the same cycle, only the pop takes effect and the pushed word is dropped.
- R9: A `flush` cycle leaves every channel empty with a count of 0.
- R10: A configuration write sets the start index and size of the channel given by `cfg_ch`. It takes effect only when all channels are empty and start + size <= 32. Any other configuration write is ignored.
- R11: A channel configured with size 0 reports full and empty together and accepts no push.
- R12: A push or pop with a channel select value of 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties all channels |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 2 | Channel whose region is written |
| cfg_base | input | 5 | Region start index |
| cfg_size | input | 6 | Region size in entries (0 disables the channel) |
| push_valid | input | 1 | Push request |
| push_ch | input | 2 | Channel to push into |
| push_data | input | 64 | Word to store |
| pop_valid | input | 1 | Pop request |
| pop_ch | input | 2 | Channel to pop from |
| pop_rvalid | output | 1 | pop_data holds a popped word |
| pop_data | output | 64 | Popped word |
| ch_full | output | 3 | Per-channel full flag |
| ch_empty | output | 3 | Per-channel empty flag |
| ch_count | output | 18 | Per-channel fill count, 6 bits each, channel 0 in the low bits |

## Verification
Counts, flags and configuration changes update at the clock edge that accepts the request. A popped word appears together with `pop_rvalid` directly after the edge that accepts the pop, so each result is due one edge after its stimulus. The bench drives each request on a falling edge and checks the flags on the next falling edge. A scoreboard queue holds the words expected from accepted pops, and a monitor compares `pop_data` against the front of that queue on every falling edge where `pop_rvalid` is high. A `pop_rvalid` with nothing expected is counted as a failure.

// File: rtl/sff_pkg.sv
package sff_pkg;

    // Default region layout: half the array for graphics, a quarter per video line
    function automatic int region_base_default(input int ch, input int depth);
        case (ch)
            0:       return 0;
            1:       return depth / 2;
            default: return (depth * 3) / 4;
        endcase
    endfunction

    function automatic int region_size_default(input int ch, input int depth);
        case (ch)
            0:       return depth / 2;
            default: return depth / 4;
        endcase
    endfunction

endpackage

// File: rtl/sff_store.sv
module sff_store #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] rd_data_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
        if (rd_en) begin
            rd_data_q <= mem_q[rd_addr];
        end
    end

    assign rd_data = rd_data_q;

endmodule

// File: rtl/sff_channel.sv
module sff_channel #(
    parameter int DEPTH    = 32,
    parameter int RST_BASE = 0,
    parameter int RST_SIZE = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_base,
    input  logic [CW-1:0] cfg_size,
    input  logic          push,
    input  logic          pop,
    output logic [AW-1:0] wr_idx,
    output logic [AW-1:0] rd_idx,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] count,
    output logic          push_ok,
    output logic          pop_ok
);

    typedef struct packed {
        logic [AW-1:0] base;
        logic [CW-1:0] size;
        logic [CW-1:0] wr_off;
        logic [CW-1:0] rd_off;
        logic [CW-1:0] count;
    } chan_t;

    chan_t s_q, s_d;
    logic [CW-1:0] wr_sum, rd_sum;
    logic [CW-1:0] last_off;

    always_comb begin
        full     = (s_q.count == s_q.size);
        empty    = (s_q.count == '0);
        push_ok  = push && !full;
        pop_ok   = pop && !empty;
        last_off = s_q.size - CW'(1);
        wr_sum   = CW'(s_q.base) + s_q.wr_off;
        rd_sum   = CW'(s_q.base) + s_q.rd_off;
        wr_idx   = wr_sum[AW-1:0];
        rd_idx   = rd_sum[AW-1:0];
        count    = s_q.count;

        s_d = s_q;
        if (push_ok) begin
            s_d.wr_off = (s_q.wr_off == last_off) ? '0 : s_q.wr_off + CW'(1);
        end
        if (pop_ok) begin
            s_d.rd_off = (s_q.rd_off == last_off) ? '0 : s_q.rd_off + CW'(1);
        end
        case ({push_ok, pop_ok})
            2'b10:   s_d.count = s_q.count + CW'(1);
            2'b01:   s_d.count = s_q.count - CW'(1);
            default: s_d.count = s_q.count;
        endcase
        if (flush || cfg_we) begin
            s_d.wr_off = '0;
            s_d.rd_off = '0;
            s_d.count  = '0;
        end
        if (cfg_we) begin
            s_d.base = cfg_base;
            s_d.size = cfg_size;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.base   <= AW'(RST_BASE);
            s_q.size   <= CW'(RST_SIZE);
        end else begin
            s_q <= s_d;
        end
    end

    // R3: the fill level never exceeds the region size
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.count <= s_q.size);

    // R3: a push into a full channel leaves the count unchanged
    a_r3_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush && !cfg_we) |=> $stable(count));

    // R4: a pop from an empty channel leaves it empty
    a_r4_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !flush && !cfg_we) |=> (count == '0));

    // R9: flush leaves the channel empty
    a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/shared_fetch_fifo.sv
module shared_fetch_fifo #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 64,
    parameter int NCH   = 3,
    localparam int AW  = $clog2(DEPTH),
    localparam int CW  = AW + 1,
    localparam int CHW = $clog2(NCH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             cfg_we,
    input  logic [CHW-1:0]   cfg_ch,
    input  logic [AW-1:0]    cfg_base,
    input  logic [CW-1:0]    cfg_size,
    input  logic             push_valid,
    input  logic [CHW-1:0]   push_ch,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop_valid,
    input  logic [CHW-1:0]   pop_ch,
    output logic             pop_rvalid,
    output logic [WIDTH-1:0] pop_data,
    output logic [NCH-1:0]   ch_full,
    output logic [NCH-1:0]   ch_empty,
    output logic [NCH*CW-1:0] ch_count
);

    import sff_pkg::*;

    typedef struct packed {
        logic rvalid;
    } top_t;

    top_t t_q, t_d;

    logic [NCH-1:0]    push_req, pop_req, push_ok, pop_ok, cfg_hit;
    logic [AW-1:0]     wr_idx [NCH];
    logic [AW-1:0]     rd_idx [NCH];
    logic [AW-1:0]     wr_addr, rd_addr;
    logic [CW:0]       fit_sum;
    logic              cfg_ok, same_ch;

    always_comb begin
        fit_sum = (CW+1)'(cfg_base) + (CW+1)'(cfg_size);
        cfg_ok  = cfg_we && (&ch_empty) && (fit_sum <= (CW+1)'(DEPTH));
        same_ch = push_valid && pop_valid && (push_ch == pop_ch);
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign push_req[c] = push_valid && (push_ch == CHW'(c)) && !same_ch;
        assign pop_req[c]  = pop_valid && (pop_ch == CHW'(c));
        assign cfg_hit[c]  = cfg_ok && (cfg_ch == CHW'(c));

        sff_channel #(
            .DEPTH    (DEPTH),
            .RST_BASE (region_base_default(c, DEPTH)),
            .RST_SIZE (region_size_default(c, DEPTH))
        ) i_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush),
            .cfg_we   (cfg_hit[c]),
            .cfg_base (cfg_base),
            .cfg_size (cfg_size),
            .push     (push_req[c]),
            .pop      (pop_req[c]),
            .wr_idx   (wr_idx[c]),
            .rd_idx   (rd_idx[c]),
            .full     (ch_full[c]),
            .empty    (ch_empty[c]),
            .count    (ch_count[c*CW +: CW]),
            .push_ok  (push_ok[c]),
            .pop_ok   (pop_ok[c])
        );
    end

    always_comb begin
        wr_addr = '0;
        rd_addr = '0;
        for (int c = 0; c < NCH; c++) begin
            wr_addr = wr_addr | (wr_idx[c] & {AW{push_ok[c]}});
            rd_addr = rd_addr | (rd_idx[c] & {AW{pop_ok[c]}});
        end
        t_d.rvalid = |pop_ok;
    end

    sff_store #(
        .DEPTH (DEPTH),
        .WIDTH (WIDTH)
    ) i_store (
        .clk     (clk),
        .wr_en   (|push_ok),
        .wr_addr (wr_addr),
        .wr_data (push_data),
        .rd_en   (|pop_ok),
        .rd_addr (rd_addr),
        .rd_data (pop_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign pop_rvalid = t_q.rvalid;

    // R2: an accepted pop yields a valid word after the next edge
    a_r2_pop_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (|pop_ok) |=> pop_rvalid);

    // R4: no word is returned when no channel accepted a pop
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(|pop_ok) |=> !pop_rvalid);

    // R7/R2: at most one channel writes and one reads per cycle
    a_r7_single_port: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(push_ok) && $onehot0(pop_ok));

    // R8: a same-channel push is never accepted alongside its pop
    a_r8_same_ch_drop: assert property (@(posedge clk) disable iff (!rst_n)
        same_ch |-> !(|push_ok));

    // R12: select value outside the channel range touches nothing
    a_r12_bad_select: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_ch >= CHW'(NCH)) |-> !(|push_ok));

endmodule

// File: tb/test_shared_fetch_fifo.sv
`timescale 1ns/1ps
module test_shared_fetch_fifo;

    localparam int NCH = 3;
    localparam int CW  = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ch = '0;
    logic [4:0]  cfg_base = '0;
    logic [5:0]  cfg_size = '0;
    logic        push_valid = 1'b0;
    logic [1:0]  push_ch = '0;
    logic [63:0] push_data = '0;
    logic        pop_valid = 1'b0;
    logic [1:0]  pop_ch = '0;
    logic        pop_rvalid;
    logic [63:0] pop_data;
    logic [2:0]  ch_full, ch_empty;
    logic [17:0] ch_count;

    int total = 0;
    int bad = 0;

    // bench model
    logic [63:0] mq0[$], mq1[$], mq2[$];
    logic [63:0] rd_exp[$];
    int msize[3];
    int mbase[3];

    always #2.5 clk = ~clk;

    shared_fetch_fifo i_shared_fetch_fifo (
        .clk, .rst_n, .flush, .cfg_we, .cfg_ch, .cfg_base, .cfg_size,
        .push_valid, .push_ch, .push_data, .pop_valid, .pop_ch,
        .pop_rvalid, .pop_data, .ch_full, .ch_empty, .ch_count
    );

    function automatic int mcount(input int c);
        case (c)
            0:       return mq0.size();
            1:       return mq1.size();
            default: return mq2.size();
        endcase
    endfunction

    task automatic record(input bit ok, input string msg);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s", msg);
        end
    endtask

    // monitor: compare returned words with scoreboard (R2, R5, R6)
    always @(negedge clk) begin
        if (rst_n && pop_rvalid) begin
            if (rd_exp.size() == 0) begin
                record(1'b0, $sformatf("R4 unexpected word actual=%h expected=none", pop_data));
            end else begin
                logic [63:0] e;
                e = rd_exp.pop_front();
                record(pop_data == e,
                    $sformatf("R2/R5/R6 pop_data actual=%h expected=%h", pop_data, e));
            end
        end
    end

    // one cycle of push and/or pop, driven at a falling edge
    task automatic step(input bit pv, input int pc, input logic [63:0] pd,
                        input bit qv, input int qc);
        bit qok, pok;
        push_valid = pv; push_ch = 2'(pc); push_data = pd;
        pop_valid  = qv; pop_ch  = 2'(qc);
        qok = qv && qc < NCH && mcount(qc) > 0;
        pok = pv && pc < NCH && !(qv && qc == pc) && mcount(pc) < msize[pc];
        if (qok) begin
            case (qc)
                0: rd_exp.push_back(mq0.pop_front());
                1: rd_exp.push_back(mq1.pop_front());
                default: rd_exp.push_back(mq2.pop_front());
            endcase
        end
        if (pok) begin
            case (pc)
                0: mq0.push_back(pd);
                1: mq1.push_back(pd);
                default: mq2.push_back(pd);
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        push_valid = 1'b0;
        pop_valid  = 1'b0;
    endtask

    task automatic configure(input int c, input int b, input int s);
        cfg_we = 1'b1; cfg_ch = 2'(c); cfg_base = 5'(b); cfg_size = 6'(s);
        if (mq0.size() == 0 && mq1.size() == 0 && mq2.size() == 0 && b + s <= 32) begin
            msize[c] = s;
            mbase[c] = b;
        end
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        mq0.delete(); mq1.delete(); mq2.delete();
        @(posedge clk);
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic check_flags(input string tag);
        for (int c = 0; c < NCH; c++) begin
            int n;
            logic ef, ee;
            logic [5:0] ac;
            n  = mcount(c);
            ef = (n == msize[c]);
            ee = (n == 0);
            ac = ch_count[c*CW +: CW];
            record(ch_full[c] == ef && ch_empty[c] == ee && int'(ac) == n,
                $sformatf("%s ch%0d full/empty/count actual=%b/%b/%0d expected=%b/%b/%0d",
                          tag, c, ch_full[c], ch_empty[c], ac, ef, ee, n));
        end
    endtask

    initial begin
        #(200000 * 5);
        record(1'b0, "watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        msize[0] = 16; msize[1] = 8; msize[2] = 8;
        mbase[0] = 0;  mbase[1] = 16; mbase[2] = 24;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_flags("R1 reset");

        // R1, R3: default sizes fill at 16 and 8
        for (int i = 0; i < 17; i++) step(1, 0, 64'hA000 + 64'(i), 0, 0);
        for (int i = 0; i < 9; i++)  step(1, 1, 64'hB000 + 64'(i), 0, 0);
        check_flags("R1/R3 fill");

        // R2: ordered pops from channel 0
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0);
        check_flags("R2 pop");

        // R7: push channel 2 while popping channel 0
        step(1, 2, 64'hC000, 1, 0);
        step(1, 2, 64'hC001, 1, 1);
        check_flags("R7 concurrent");

        // R8: same channel push and pop, push dropped
        step(1, 2, 64'hDEAD, 1, 2);
        check_flags("R8 same channel");

        // R4: pop from empty channel 2 (now holds one word; drain it first)
        step(0, 0, 0, 1, 2);
        step(0, 0, 0, 1, 2);
        record(pop_rvalid == 1'b0,
               $sformatf("R4 rvalid after empty pop actual=%b expected=0", pop_rvalid));
        check_flags("R4 empty pop");

        // R12: select 3 ignored
        step(1, 3, 64'hFFFF, 0, 0);
        step(0, 0, 0, 1, 3);
        record(pop_rvalid == 1'b0,
               $sformatf("R12 rvalid after select 3 actual=%b expected=0", pop_rvalid));
        check_flags("R12 bad select");

        // R6, R5: wrap channel 1 many times while interleaving channel 2
        for (int i = 0; i < 24; i++) begin
            step(1, 1, 64'hE000 + 64'(i), 1, 1);
            step(1, 1, 64'hE100 + 64'(i), 1, 2);
            step(1, 2, 64'hF000 + 64'(i), 1, 1);
        end
        check_flags("R6 wrap");

        // R10: configuration while not empty is ignored
        configure(0, 0, 4);
        check_flags("R10 busy cfg");

        // R9: flush
        do_flush();
        rd_exp.delete();
        check_flags("R9 flush");

        // R10: accepted and rejected configurations
        configure(0, 0, 8);
        configure(1, 8, 20);
        configure(1, 20, 16);
        configure(2, 28, 0);
        for (int i = 0; i < 9; i++)  step(1, 0, 64'h1000 + 64'(i), 0, 0);
        for (int i = 0; i < 21; i++) step(1, 1, 64'h2000 + 64'(i), 0, 0);
        // R11: disabled channel takes no push
        step(1, 2, 64'h3000, 0, 0);
        check_flags("R10/R11 new layout");

        // drain everything, scoreboard checks order and isolation (R5)
        for (int i = 0; i < 9; i++)  step(0, 0, 0, 1, 0);
        for (int i = 0; i < 21; i++) step(0, 0, 0, 1, 1);
        step(0, 0, 0, 1, 2);
        check_flags("R5 drained");
        record(rd_exp.size() == 0,
               $sformatf("R2 outstanding words actual=%0d expected=0", rd_exp.size()));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule